// File: doc/BRIEF.md
# Protection-Aware Memory Checksum Unit

This block forms the 16-bit checksum of a device memory image. A pass begins with a one-cycle start pulse. On that pulse the unit captures the configuration word, the four identification words and a device-size select. From these it works out which program addresses count toward the total and whether a packed identification term joins the sum. It then accepts a stream of (address, 14-bit word) beats on a valid/ready handshake, adds the words whose address lies inside the selected window, and signals completion with a one-cycle done strobe after the beat flagged as last.

The total is kept modulo 2^16. The configuration word is masked before it is added. The identification term packs the low nibble of each identification word into one 16-bit value, with word 0 in the top nibble. The protection field is the upper four configuration bits, which hold two copies of a two-bit code. A code of all ones means the image is open: the whole device is summed and no identification term is added. Any other code shrinks the summed window and adds the identification term.

The sequencer has three states. IDLE waits, and a start pulse moves it to RUN. RUN accepts beats, and the beat flagged last moves it to DONE. DONE lasts exactly one cycle and always returns to IDLE.

Top module: `image_csum_unit`

## Requirements
- R1: After reset, `sum` is 0, `done` is 0 and `in_ready` is 0.
- R2: A start pulse in IDLE loads the running total with `cfg_word & 0x3DFF`, plus the identification term when that term is enabled. The loaded value appears on `sum` in the next cycle, and `in_ready` rises in that same cycle.
- R3: The identification term places the low 4 bits of identification word k in sum bits [15-4k:12-4k], so word 0 is the most significant nibble. Word k occupies `id_words[14k+13:14k]`. Words 1, 2, 3, 4 give 0x1234.
- R4: The effective protection code is `cfg_word[13:12] & cfg_word[11:10]`, so a cleared bit in either copy counts. A code of 11 means the image is open.
- R5: With `size_full`=1, the summed window and identification term depend on the code:
  - 11: addresses below 0x800, no identification term.
  - 10: addresses below 0x400, identification term added.
  - 01: addresses below 0x200, identification term added.
  - 00: no addresses, identification term added.
- R6: With `size_full`=0, the summed window and identification term depend on the code:
  - 11 or 10: addresses below 0x400, no identification term.
  - 01: addresses below 0x200, identification term added.
  - 00: no addresses, identification term added.
- R7: A beat whose address lies outside the window is accepted (`in_ready` high) but leaves the total unchanged.
- R8: The total wraps modulo 2^16, and carries out of bit 15 are dropped.
- R9: `done` is high for exactly the one cycle after the last beat is accepted. `sum` then holds the final total until the next start, and `in_ready` is low from DONE onward.
- R10: A start pulse during RUN is ignored. The total, the window and the pass all carry on unchanged.
- R11: A blank full-size image (every word 0x3FFF, configuration 0x3FFF, open) gives 0x35FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that begins a pass |
| size_full | input | 1 | 1 = full-size device, 0 = half-size device |
| cfg_word | input | 14 | Configuration word, captured on start |
| id_words | input | 56 | Four identification words, word k at bits [14k+13:14k] |
| in_valid | input | 1 | Beat valid |
| in_ready | output | 1 | Beat accepted when high together with in_valid |
| in_addr | input | 13 | Word address of the beat |
| in_data | input | 14 | Memory word of the beat |
| in_last | input | 1 | Marks the final beat of the pass |
| sum | output | 16 | Running and final checksum |
| done | output | 1 | One-cycle strobe after the final beat |

## Verification
The bench runs every protection code at both device sizes. Each run streams the whole full-size address range plus beats at addresses far above it, so a window bound that is off by one, or taken from the wrong size, changes the total. A decoder that reads only one copy of the protection code would be caught by a run whose two copies disagree. A packer with reversed nibble order would be caught by asymmetric identification words. An ID term added on open images would also show up in the total. Two further runs target the sequencer and the accumulator. The blank image checks the masked configuration and the wrap-around. A start pulse injected mid-stream would, in a faulty design, reload the total or restart the pass.

// File: rtl/csum_pkg.sv
package csum_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } csum_state_t;

    localparam logic [13:0] CFG_SUM_MASK = 14'h3DFF;
    localparam logic [1:0]  CP_OPEN      = 2'b11;

endpackage

// File: rtl/prot_window_dec.sv
module prot_window_dec #(
    parameter int FULL_WORDS = 2048,
    parameter int LIM_W      = 14
) (
    input  logic [3:0]       cp_field,
    input  logic             size_full,
    output logic [LIM_W-1:0] limit,
    output logic             id_en
);
    import csum_pkg::*;

    localparam int L_FULL = FULL_WORDS;
    localparam int L_HALF = FULL_WORDS / 2;
    localparam int L_QTR  = FULL_WORDS / 4;

    logic [1:0] cp_eff;

    always_comb begin
        cp_eff = cp_field[3:2] & cp_field[1:0];
        limit  = '0;
        id_en  = 1'b1;
        unique case (cp_eff)
            CP_OPEN: begin
                id_en = 1'b0;
                limit = size_full ? LIM_W'(L_FULL) : LIM_W'(L_HALF);
            end
            2'b10: begin
                id_en = size_full;
                limit = LIM_W'(L_HALF);
            end
            2'b01: begin
                limit = LIM_W'(L_QTR);
            end
            default: begin
                limit = '0;
            end
        endcase
    end

endmodule

// File: rtl/id_nibble_pack.sv
module id_nibble_pack #(
    parameter int WORD_W = 14,
    parameter int ID_N   = 4,
    parameter int NIB_W  = 4,
    parameter int SUM_W  = ID_N * NIB_W
) (
    input  logic [ID_N*WORD_W-1:0] id_words,
    output logic [SUM_W-1:0]       id_term
);

    logic unused_id_upper;
    assign unused_id_upper = ^id_words;

    for (genvar k = 0; k < ID_N; k++) begin : g_nib
        assign id_term[SUM_W-1-NIB_W*k -: NIB_W] = id_words[k*WORD_W +: NIB_W];
    end

endmodule

// File: rtl/csum_seq.sv
module csum_seq #(
    parameter int ADDR_W = 13,
    parameter int WORD_W = 14,
    parameter int SUM_W  = 16,
    parameter int LIM_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SUM_W-1:0]  init_val,
    input  logic [LIM_W-1:0]  limit,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              done,
    output logic [SUM_W-1:0]  sum
);
    import csum_pkg::*;

    csum_state_t       state_q, state_d;
    logic [LIM_W-1:0]  limit_q;
    logic [SUM_W-1:0]  acc_q;
    logic              take;
    logic              in_range;
    logic              launch;

    assign launch   = (state_q == ST_IDLE) && start;
    assign take     = (state_q == ST_RUN) && in_valid;
    assign in_range = ({{(LIM_W-ADDR_W){1'b0}}, in_addr} < limit_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)            state_d = ST_RUN;
            ST_RUN:  if (in_valid && in_last) state_d = ST_DONE;
            ST_DONE:                       state_d = ST_IDLE;
            default:                       state_d = ST_IDLE;
        endcase
    end

    // window and accumulator
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            limit_q <= '0;
            acc_q   <= '0;
        end else if (launch) begin
            limit_q <= limit;
            acc_q   <= init_val;
        end else if (take && in_range) begin
            acc_q   <= acc_q + {{(SUM_W-WORD_W){1'b0}}, in_data};
        end
    end

    // outputs
    always_comb begin
        in_ready = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN:  in_ready = 1'b1;
            ST_DONE: done     = 1'b1;
            default: ;
        endcase
    end

    assign sum = acc_q;

    assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(in_valid && in_ready && in_last));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_skip_outside_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_range) |=> $stable(acc_q));

    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && start && !in_valid) |=> (in_ready && $stable(acc_q)));

    assert_sum_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !start) |=> $stable(sum));

endmodule

// File: rtl/image_csum_unit.sv
module image_csum_unit #(
    parameter int ADDR_W     = 13,
    parameter int WORD_W     = 14,
    parameter int SUM_W      = 16,
    parameter int ID_N       = 4,
    parameter int FULL_WORDS = 2048
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   size_full,
    input  logic [WORD_W-1:0]      cfg_word,
    input  logic [ID_N*WORD_W-1:0] id_words,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [ADDR_W-1:0]      in_addr,
    input  logic [WORD_W-1:0]      in_data,
    input  logic                   in_last,
    output logic [SUM_W-1:0]       sum,
    output logic                   done
);
    import csum_pkg::*;

    localparam int LIM_W = ADDR_W + 1;
    localparam int NIB_W = SUM_W / ID_N;

    logic [LIM_W-1:0] limit;
    logic             id_en;
    logic [SUM_W-1:0] id_term;
    logic [SUM_W-1:0] cfg_term;
    logic [SUM_W-1:0] init_val;

    prot_window_dec #(.FULL_WORDS(FULL_WORDS), .LIM_W(LIM_W)) u_dec (
        .cp_field (cfg_word[WORD_W-1 -: 4]),
        .size_full(size_full),
        .limit    (limit),
        .id_en    (id_en)
    );

    id_nibble_pack #(.WORD_W(WORD_W), .ID_N(ID_N), .NIB_W(NIB_W), .SUM_W(SUM_W)) u_pack (
        .id_words(id_words),
        .id_term (id_term)
    );

    assign cfg_term = {{(SUM_W-WORD_W){1'b0}}, cfg_word & CFG_SUM_MASK};
    assign init_val = cfg_term + (id_en ? id_term : '0);

    csum_seq #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .SUM_W(SUM_W), .LIM_W(LIM_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .init_val(init_val),
        .limit   (limit),
        .in_valid(in_valid),
        .in_addr (in_addr),
        .in_data (in_data),
        .in_last (in_last),
        .in_ready(in_ready),
        .done    (done),
        .sum     (sum)
    );

    assert_open_no_id_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !in_ready && !done && (cfg_word[WORD_W-1 -: 4] == 4'hF))
        |=> (sum == $past(cfg_term)));

endmodule

// File: tb/image_csum_unit_bench.sv
module image_csum_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        size_full = 1'b1;
    logic [13:0] cfg_word = '0;
    logic [55:0] id_words = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [12:0] in_addr = '0;
    logic [13:0] in_data = '0;
    logic        in_last = 1'b0;
    logic [15:0] sum;
    logic        done;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    image_csum_unit u_image_csum_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .size_full(size_full),
        .cfg_word(cfg_word), .id_words(id_words), .in_valid(in_valid),
        .in_ready(in_ready), .in_addr(in_addr), .in_data(in_data),
        .in_last(in_last), .sum(sum), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [13:0] gen(input int addr, input int seed, input bit blank);
        if (blank) return 14'h3FFF;
        return 14'((addr * 37 + seed * 101) ^ (addr >> 3) ^ (seed << 7));
    endfunction

    // window per R4, R5, R6
    function automatic void plan(input logic [13:0] cfg, input bit full,
                                 output int lim, output bit use_id);
        logic [1:0] e;
        e = cfg[13:12] & cfg[11:10];
        if (e == 2'b11)      begin lim = full ? 2048 : 1024; use_id = 1'b0; end
        else if (e == 2'b10) begin lim = 1024; use_id = full; end
        else if (e == 2'b01) begin lim = 512;  use_id = 1'b1; end
        else                 begin lim = 0;    use_id = 1'b1; end
    endfunction

    // R3 packing
    function automatic int idterm(input logic [55:0] ids);
        int t = 0;
        for (int k = 0; k < 4; k++) t = t | (int'(ids[14*k +: 4]) << (12 - 4*k));
        return t;
    endfunction

    task automatic run_pass(input logic [13:0] cfg, input logic [55:0] ids, input bit full,
                            input int seed, input bit blank, input bit poke, input string tag);
        int lim;
        bit use_id;
        int init;
        int exp;
        int total;
        plan(cfg, full, lim, use_id);
        init = (int'(cfg & 14'h3DFF) + (use_id ? idterm(ids) : 0)) & 16'hFFFF;
        exp  = init;
        total = 2048 + 3;
        @(negedge clk);
        cfg_word = cfg; id_words = ids; size_full = full; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(sum == 16'(init), {tag, " R2 R3 initial total"}, sum, init);
        chk(in_ready == 1'b1, {tag, " R2 ready after start"}, in_ready, 1);
        for (int i = 0; i < total; i++) begin
            int a;
            logic [13:0] d;
            a = (i < 2048) ? i : (13'h1000 + i);
            d = gen(a, seed, blank);
            if (i % 7 == 3) begin
                in_valid = 1'b0;
                if (poke && i == 10) begin
                    start = 1'b1;
                    cfg_word = 14'h0000;
                end
                @(negedge clk);
                start = 1'b0;
                cfg_word = cfg;
                if (poke && i == 10) begin
                    chk(in_ready == 1'b1, {tag, " R10 pass continues"}, in_ready, 1);
                end
            end
            in_valid = 1'b1;
            in_addr  = 13'(a);
            in_data  = d;
            in_last  = (i == total - 1);
            if (a < lim) exp = (exp + int'(d)) & 16'hFFFF;
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        chk(done == 1'b1, {tag, " R9 done strobe"}, done, 1);
        chk(sum == 16'(exp), {tag, " R5 R6 R7 R8 final total"}, sum, exp);
        @(negedge clk);
        chk(done == 1'b0 && in_ready == 1'b0, {tag, " R9 strobe is single"},
            {done, in_ready}, 0);
        chk(sum == 16'(exp), {tag, " R9 total holds"}, sum, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [55:0] ids;
        ids = {14'h2A04, 14'h3FC3, 14'h1152, 14'h0E01};
        repeat (3) @(negedge clk);
        chk(sum == 0 && done == 0 && in_ready == 0, "R1 reset state",
            {sum, done, in_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b0, "R1 idle not ready", in_ready, 0);
        // R3 example word values 1,2,3,4 with code 00
        run_pass(14'h03A5, {14'h4, 14'h3, 14'h2, 14'h1}, 1'b1, 9, 1'b0, 1'b0, "R3 example");
        // R5 full-size sweep
        run_pass(14'h3D6E, ids, 1'b1, 1, 1'b0, 1'b0, "R5 cp11");
        run_pass(14'h2A31, ids, 1'b1, 2, 1'b0, 1'b0, "R5 cp10");
        run_pass(14'h1477, ids, 1'b1, 3, 1'b0, 1'b0, "R5 cp01");
        run_pass(14'h00FF, ids, 1'b1, 4, 1'b0, 1'b0, "R5 cp00");
        // R6 half-size sweep
        run_pass(14'h3C12, ids, 1'b0, 5, 1'b0, 1'b0, "R6 cp11");
        run_pass(14'h2BCD, ids, 1'b0, 6, 1'b0, 1'b0, "R6 cp10");
        run_pass(14'h1508, ids, 1'b0, 7, 1'b0, 1'b0, "R6 cp01");
        run_pass(14'h0333, ids, 1'b0, 8, 1'b0, 1'b0, "R6 cp00");
        // R4 copies disagree: 11 and 01 -> 01
        run_pass(14'h3555, ids, 1'b1, 10, 1'b0, 1'b0, "R4 mixed copies");
        // R11 blank image, R8 wrap
        run_pass(14'h3FFF, ids, 1'b1, 0, 1'b1, 1'b0, "R11 blank");
        chk(sum == 16'h35FF, "R11 blank constant", sum, 16'h35FF);
        // R10 start during run
        run_pass(14'h3FFF, ids, 1'b1, 11, 1'b0, 1'b1, "R10 poke");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule